// File: doc/BRIEF.md
# Per-Slave Bus Arbiter with Selectable Scheme and Idle Parking

This block sits in front of one slave port of a multi-master interconnect and decides which master owns that port. Every master raises a request line; the arbiter answers with a registered grant vector in which at most one bit is set. Each slave port gets its own copy, so the scheme, the priority levels, the idle policy and the set of masters allowed to reach that slave are configured separately for every port.

Two schemes are available at run time: fixed priority, where each master carries a programmable level, and round robin, where the search rotates from the master after the previous owner. Ownership only moves at transfer boundaries: once a master wins, it keeps the port until the transfer-end input is seen. When nobody is asking, the grant either drops to zero or parks on a default master (the previous owner or a configured one), so that master can start its next access without waiting a cycle for arbitration.

Top module: `bus_slot_arbiter`

## Requirements
- R1: The grant vector is a registered output with at most one bit set; it is all zeros while reset is asserted and just after it.
- R2: A master whose bit in `cfg_en` is 0 is never granted, neither for a request nor as a parked default.
- R3: With `cfg_rr` = 0, the winner among enabled requesters is the one whose priority field (`cfg_prio[i*PW +: PW]`, larger value wins) is highest; on equal levels the lowest index wins.
- R4: With `cfg_rr` = 1, the winner is the first enabled requester found searching upward, with wrap-around, from the index after the most recently granted requester; after reset that index is NM-1, so the search starts at master 0.
- R5: Once a requester has been granted, the grant stays unchanged until `xfer_end` is sampled high, whatever the request lines do meanwhile.
- R6: With `cfg_dflt` = 0 (code 3 behaves the same), no grant is asserted at a boundary where no enabled master requests.
- R7: With `cfg_dflt` = 1, the grant parks on the most recently granted requester when no enabled master requests; before any request has been granted since reset, nothing is parked.
- R8: With `cfg_dflt` = 2, the grant parks on master `cfg_dflt_id` when no enabled master requests; if that master is disabled, nothing is parked.
- R9: A parked grant is not an ownership: while parked, any enabled request is arbitrated in the next cycle, so the parked master keeps its grant with no gap when it wins, and loses it to a better requester otherwise.
- R10: If the owner's `cfg_en` bit is cleared during a transfer, the port is re-arbitrated at the next clock edge as if the transfer had ended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | NM | Request line per master |
| xfer_end | input | 1 | Current owner's transfer or burst ends this cycle |
| cfg_rr | input | 1 | Scheme: 0 fixed priority, 1 round robin |
| cfg_dflt | input | 2 | Idle policy: 0 none, 1 previous owner, 2 fixed master, 3 none |
| cfg_dflt_id | input | IW | Index of the fixed default master |
| cfg_en | input | NM | Per-master access enable mask |
| cfg_prio | input | NM*PW | Priority level per master, field i at bits i*PW upward |
| gnt | output | NM | Registered grant, one-hot or zero |

## Verification
The bench builds the arbiter with four masters and two-bit priority fields. Four masters are enough for the round-robin search to skip non-requesters and wrap past the top index, and for a mask to remove the current owner mid-transfer; four priority levels allow a high-index master to beat lower ones while equal levels still exercise the lowest-index tie break. Both parking policies are run against a competing requester to show a parked grant moving or staying.

// File: rtl/bus_slot_arbiter.sv
module bus_slot_arbiter #(
  parameter int NM = 4,
  parameter int PW = 2,
  localparam int IW = (NM > 1) ? $clog2(NM) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NM-1:0]     req,
  input  logic              xfer_end,
  input  logic              cfg_rr,
  input  logic [1:0]        cfg_dflt,
  input  logic [IW-1:0]     cfg_dflt_id,
  input  logic [NM-1:0]     cfg_en,
  input  logic [NM*PW-1:0]  cfg_prio,
  output logic [NM-1:0]     gnt
);

  logic          busy_q;
  logic [NM-1:0] gnt_q;
  logic [IW-1:0] last_q;
  logic          lastv_q;

  logic [NM-1:0] elig;
  logic          own_ok, boundary, any_req;
  logic [IW-1:0] fp_idx, rr_idx, win;
  logic [PW-1:0] best;
  logic          fp_found, rr_found;
  logic [NM-1:0] park;

  assign elig     = req & cfg_en;
  assign any_req  = |elig;
  assign own_ok   = |(gnt_q & cfg_en);
  assign boundary = !busy_q || xfer_end || !own_ok;
  assign gnt      = gnt_q;

  always_comb begin
    fp_idx   = '0;
    best     = '0;
    fp_found = 1'b0;
    for (int i = 0; i < NM; i++) begin
      if (elig[i] && (!fp_found || cfg_prio[i*PW +: PW] > best)) begin
        fp_found = 1'b1;
        best     = cfg_prio[i*PW +: PW];
        fp_idx   = IW'(i);
      end
    end
  end

  always_comb begin
    rr_idx   = '0;
    rr_found = 1'b0;
    for (int k = 1; k <= NM; k++) begin
      int j;
      j = (int'(last_q) + k) % NM;
      if (!rr_found && elig[j]) begin
        rr_found = 1'b1;
        rr_idx   = IW'(j);
      end
    end
  end

  assign win = cfg_rr ? rr_idx : fp_idx;

  always_comb begin
    case (cfg_dflt)
      2'd1:    park = lastv_q ? (NM'(1) << last_q) : '0;
      2'd2:    park = (int'(cfg_dflt_id) < NM) ? (NM'(1) << cfg_dflt_id) : '0;
      default: park = '0;
    endcase
    park = park & cfg_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      gnt_q   <= '0;
      last_q  <= IW'(NM-1);
      lastv_q <= 1'b0;
    end else if (boundary) begin
      if (any_req) begin
        busy_q  <= 1'b1;
        gnt_q   <= NM'(1) << win;
        last_q  <= win;
        lastv_q <= 1'b1;
      end else begin
        busy_q  <= 1'b0;
        gnt_q   <= park;
      end
    end
  end

endmodule

module bus_slot_arbiter_chk #(
  parameter int NM = 4,
  parameter int PW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic [NM-1:0] req,
  input logic          xfer_end,
  input logic [1:0]    cfg_dflt,
  input logic [NM-1:0] cfg_en,
  input logic [NM-1:0] gnt,
  input logic          busy
);

  p_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));

  p_masked_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt & ~$past(cfg_en)) == '0);

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !xfer_end && |(gnt & cfg_en)) |=> $stable(gnt));

  p_idle_none_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_dflt == 2'd0 && (req & cfg_en) == '0 && (!busy || xfer_end)) |=> gnt == '0);

  p_serve_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && |(req & cfg_en)) |=> |(gnt & $past(req)));

endmodule

bind bus_slot_arbiter bus_slot_arbiter_chk #(.NM(NM), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .xfer_end(xfer_end),
  .cfg_dflt(cfg_dflt), .cfg_en(cfg_en), .gnt(gnt), .busy(busy_q)
);

// File: tb/sim_bus_slot_arbiter.sv
module sim_bus_slot_arbiter;
  localparam int NM = 4;
  localparam int PW = 2;
  localparam int IW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NM-1:0] req = '0;
  logic xfer_end = 1'b0;
  logic cfg_rr = 1'b0;
  logic [1:0] cfg_dflt = 2'd1;
  logic [IW-1:0] cfg_dflt_id = '0;
  logic [NM-1:0] cfg_en = '1;
  logic [NM*PW-1:0] cfg_prio = '0;
  logic [NM-1:0] gnt;

  int checks = 0;
  int errors = 0;
  logic [NM-1:0] exp_q[$];
  string tag_q[$];
  bit done = 1'b0;

  always #4 clk = ~clk;

  bus_slot_arbiter #(.NM(NM), .PW(PW)) u0 (
    .clk(clk), .rst_n(rst_n), .req(req), .xfer_end(xfer_end),
    .cfg_rr(cfg_rr), .cfg_dflt(cfg_dflt), .cfg_dflt_id(cfg_dflt_id),
    .cfg_en(cfg_en), .cfg_prio(cfg_prio), .gnt(gnt)
  );

  task automatic cmp(input logic [NM-1:0] act, input logic [NM-1:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: gnt=%b expected %b", tag, act, exp);
    end
  endtask

  // inputs already set; expected grant after the coming edge
  task automatic step(input logic [NM-1:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
  endtask

  initial begin : monitor
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) cmp(gnt, exp_q.pop_front(), tag_q.pop_front());
    end
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    cmp(gnt, '0, "R1 reset");
    rst_n = 1'b1;
    @(negedge clk);
    step(4'b0000, "R7 no park before any grant");
    cfg_dflt = 2'd0;
    req = 4'b0110; step(4'b0010, "R3 tie lowest index");
    req = 4'b1111; step(4'b0010, "R5 hold without xfer_end");
    xfer_end = 1'b1; step(4'b0001, "R3 equal levels");
    cfg_prio = 8'b11_01_00_00; step(4'b1000, "R3 highest level");
    req = 4'b0000; step(4'b0000, "R6 idle no grant");
    xfer_end = 1'b0; step(4'b0000, "R6 idle stays");
    cfg_rr = 1'b1;
    req = 4'b1111; step(4'b0001, "R4 wrap after last");
    xfer_end = 1'b1; step(4'b0010, "R4 next after owner");
    req = 4'b1001; step(4'b1000, "R4 skip idle master");
    req = 4'b1111; step(4'b0001, "R4 wrap to zero");
    cfg_en = 4'b1110; req = 4'b0001; step(4'b0000, "R2 disabled requester");
    req = 4'b0011; step(4'b0010, "R2 enabled requester wins");
    xfer_end = 1'b0; cfg_en = 4'b1100; step(4'b0000, "R10 owner disabled");
    cfg_en = 4'b1111; cfg_dflt = 2'd1; req = 4'b0000; step(4'b0010, "R7 park previous owner");
    req = 4'b0010; step(4'b0010, "R9 parked master keeps grant");
    xfer_end = 1'b1; req = 4'b0000; step(4'b0010, "R7 park after transfer");
    cfg_dflt = 2'd2; cfg_dflt_id = 2'd2; step(4'b0100, "R8 park fixed master");
    cfg_rr = 1'b0; cfg_prio = '0; xfer_end = 1'b0; req = 4'b0101; step(4'b0001, "R9 parked master loses");
    xfer_end = 1'b1; req = 4'b0000; step(4'b0100, "R8 park again");
    cfg_en = 4'b1011; step(4'b0000, "R8 disabled default");
    step(4'b0000, "R2 disabled default stays off");
    repeat (2) @(negedge clk);
    done = 1'b1;
  end

  initial begin : finish_ctl
    fork
      wait (done);
      begin
        repeat (2000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule